// File: doc/BRIEF.md
# Carry-Conditional Relative Branch Unit

This unit executes a short, program-counter-relative branch that is taken only when the carry flag is set. Each instruction cycle has four phases, Q1 to Q4, and the unit produces them itself. The caller holds the 16-bit instruction word steady for a whole instruction cycle and supplies the carry flag. The unit keeps the byte-addressed program counter. While an instruction executes, that counter already points one word (2 bytes) past it.

The low byte of a branch word is a signed word offset. It is sign-extended, doubled and added to the advanced counter, and the sum wraps at the counter width. A taken branch loads the counter at the end of Q4. The unit then raises a flush marker for the whole following instruction cycle. In that cycle the fetched word is thrown away and the counter just steps by 2. A branch that is not taken, and any other instruction word, simply step the counter by 2. The unit never writes any flag.

Top module: `bcu_top`

## Requirements
- R1: While `rstN` is low, `pc` equals `RESET_PC` with bit 0 cleared, `phase` is 0 (Q1) and `flush` is 0.
- R2: After reset, `phase` steps 0,1,2,3,0,... (Q1,Q2,Q3,Q4) on every clock.
- R3: `pc` changes only on the clock edge that ends Q4, so it is stable during Q2, Q3 and Q4.
- R4: A word whose bits [15:8] equal 8'hE2 is a branch, and bits [7:0] hold the two's-complement offset n. The carry flag is sampled on the edge that ends Q3, and only that sample counts. If the sample is 1, `pc` becomes `pc + 2*n`, which equals the branch address + 2 + 2n.
- R5: If the carry sample is 0, or the word is not a branch (bits [15:8] are not 8'hE2), `pc` becomes `pc + 2` and `flush` stays 0.
- R6: After a taken branch, `flush` is 1 for exactly the next instruction cycle (Q1 through Q4) and then returns to 0.
- R7: During a flush cycle the instruction word is ignored. Even a branch word with carry 1 only steps `pc` by 2 and raises no new flush.
- R8: The target addition wraps modulo 2^PC_W in both directions, including the offsets -128 and 127.
- R9: Bit 0 of `pc` is always 0.
- R10: A branch with n = 5 at address A leads to `pc` = A + 12 when carry is 1. When carry is 0, the next instruction executes at A + 2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Phase clock; four edges make one instruction cycle |
| rstN | input | 1 | Asynchronous active-low reset |
| instrWord | input | 16 | Instruction word, held for the whole instruction cycle |
| carryIn | input | 1 | Current carry flag, sampled at the end of Q3 |
| pc | output | PC_W | Byte-addressed program counter, already advanced past the executing word |
| phase | output | 2 | Current phase: 0=Q1, 1=Q2, 2=Q3, 3=Q4 |
| flush | output | 1 | High for the whole idle cycle that follows a taken branch |

## Verification
The phase output moves one step per clock. Every counter result lands on the edge that ends Q4 and first shows in the following Q1. The flush marker rises and falls on those same Q4-to-Q1 edges. A behavioural model in the bench follows the same edges and is compared against the outputs on every falling clock edge. The directed checks run once per instruction cycle, at the falling edge inside the next Q1, which is the first point where the new counter value is visible. One stimulus raises carry only during Q3 and another drops it only during Q3, which pins the carry sample to the end of Q3.

// File: rtl/bcu_pkg.sv
package bcu_pkg;
  localparam int OFF_W = 8;
  localparam logic [7:0] BC_OPCODE = 8'hE2;

  typedef enum logic [1:0] {
    PH_Q1 = 2'd0,
    PH_Q2 = 2'd1,
    PH_Q3 = 2'd2,
    PH_Q4 = 2'd3
  } phase_e;

  typedef struct packed {
    logic grabOffset;
    logic pcLoad;
    logic pcStep;
  } dpStrobe_t;
endpackage

// File: rtl/bcu_ctrl.sv
module bcu_ctrl
  import bcu_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  logic [7:0]      opHigh,
  input  logic            carryIn,
  output dpStrobe_t       strobe,
  output logic [1:0]      phaseOut,
  output logic            flushOut
);
  phase_e phaseQ;
  logic   isBcQ;
  logic   takeQ;
  logic   flushQ;
  logic [1:0] phaseNext;

  assign phaseNext = phaseQ + 2'd1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phaseQ <= PH_Q1;
      isBcQ  <= 1'b0;
      takeQ  <= 1'b0;
      flushQ <= 1'b0;
    end else begin
      phaseQ <= phase_e'(phaseNext);
      case (phaseQ)
        PH_Q1: isBcQ <= !flushQ && (opHigh == BC_OPCODE);
        PH_Q2: ;
        PH_Q3: takeQ <= isBcQ && carryIn;
        PH_Q4: begin
          flushQ <= takeQ;
          takeQ  <= 1'b0;
          isBcQ  <= 1'b0;
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    strobe.grabOffset = (phaseQ == PH_Q2) && !flushQ;
    strobe.pcLoad     = (phaseQ == PH_Q4) && takeQ;
    strobe.pcStep     = (phaseQ == PH_Q4) && !takeQ;
  end

  assign phaseOut = phaseQ;
  assign flushOut = flushQ;
endmodule

// File: rtl/bcu_dp.sv
module bcu_dp
  import bcu_pkg::*;
#(
  parameter int              PC_W     = 16,
  parameter logic [PC_W-1:0] RESET_PC = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobe_t        strobe,
  input  logic [OFF_W-1:0] offsetIn,
  output logic [PC_W-1:0]  pcOut
);
  localparam int EXT_W = PC_W - OFF_W - 1;
  localparam logic [PC_W-1:0] PC_INIT = {RESET_PC[PC_W-1:1], 1'b0};
  localparam logic [PC_W-1:0] WORD_BYTES = PC_W'(2);

  logic [OFF_W-1:0] offsetQ;
  logic [PC_W-1:0]  pcQ;
  logic [PC_W-1:0]  byteDisp;
  logic [PC_W-1:0]  targetPc;

  // Signed word offset -> byte displacement, sign-extended to the counter width
  assign byteDisp = {{EXT_W{offsetQ[OFF_W-1]}}, offsetQ, 1'b0};
  assign targetPc = pcQ + byteDisp;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      offsetQ <= '0;
      pcQ     <= PC_INIT;
    end else begin
      if (strobe.grabOffset) offsetQ <= offsetIn;
      if (strobe.pcLoad)      pcQ <= targetPc;
      else if (strobe.pcStep) pcQ <= pcQ + WORD_BYTES;
    end
  end

  assign pcOut = pcQ;
endmodule

// File: rtl/bcu_top.sv
module bcu_top
  import bcu_pkg::*;
#(
  parameter int              PC_W     = 16,
  parameter logic [PC_W-1:0] RESET_PC = '0
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [15:0]     instrWord,
  input  logic            carryIn,
  output logic [PC_W-1:0] pc,
  output logic [1:0]      phase,
  output logic            flush
);
  dpStrobe_t strobe;

  bcu_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .opHigh   (instrWord[15:8]),
    .carryIn  (carryIn),
    .strobe   (strobe),
    .phaseOut (phase),
    .flushOut (flush)
  );

  bcu_dp #(.PC_W(PC_W), .RESET_PC(RESET_PC)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .offsetIn (instrWord[OFF_W-1:0]),
    .pcOut    (pc)
  );
endmodule

// File: rtl/bcu_chk.sv
module bcu_chk #(
  parameter int PC_W = 16
) (
  input logic            clk,
  input logic            rstN,
  input logic [15:0]     instrWord,
  input logic [PC_W-1:0] pc,
  input logic [1:0]      phase,
  input logic            flush
);
  // R2
  phase_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> phase == 2'($past(phase) + 2'd1));

  // R3
  pc_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (phase != 2'd0) |-> $stable(pc));

  // R6
  flush_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (phase != 2'd0) |-> $stable(flush));

  // R6
  flush_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    (phase == 2'd3 && flush) |=> !flush);

  // R7
  flush_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (phase == 2'd3 && flush) |=> pc == PC_W'($past(pc) + PC_W'(2)));

  // R5
  plain_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (phase == 2'd3 && !flush && instrWord[15:8] != 8'hE2)
      |=> (pc == PC_W'($past(pc) + PC_W'(2))) && !flush);

  // R9
  pc_even_chk: assert property (@(posedge clk) disable iff (!rstN)
    !pc[0]);
endmodule

bind bcu_top bcu_chk #(.PC_W(PC_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .instrWord (instrWord),
  .pc        (pc),
  .phase     (phase),
  .flush     (flush)
);

// File: tb/bcu_top_tb.sv
module bcu_top_tb;
  localparam int CLK_PERIOD = 10;
  localparam int PC_W = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [15:0] instrWord = 16'h0000;
  logic carryIn = 1'b0;
  logic [PC_W-1:0] pc;
  logic [1:0] phase;
  logic flush;

  int checks = 0;
  int errors = 0;

  logic [PC_W-1:0] refPc = '0;
  int refPhase = 0;
  bit refFlush = 1'b0;
  bit refTake = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bcu_top #(.PC_W(PC_W), .RESET_PC(16'h0000)) u_dut (
    .clk(clk), .rstN(rstN), .instrWord(instrWord), .carryIn(carryIn),
    .pc(pc), .phase(phase), .flush(flush)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Behavioural reference: one instruction cycle = four clocks
  always @(posedge clk) begin
    if (!rstN) begin
      refPc <= '0; refPhase <= 0; refFlush <= 1'b0; refTake <= 1'b0;
    end else begin
      if (refPhase == 2)
        refTake <= !refFlush && (instrWord[15:8] == 8'hE2) && carryIn;
      if (refPhase == 3) begin
        if (refTake) refPc <= refPc + PC_W'(2 * $signed(instrWord[7:0]));
        else         refPc <= refPc + PC_W'(2);
        refFlush <= refTake;
        refTake  <= 1'b0;
      end
      refPhase <= (refPhase + 1) % 4;
    end
  end

  always @(negedge clk) begin
    if (rstN) begin
      check(pc == refPc, "R3", "pc vs model", pc, refPc);
      check(phase == 2'(refPhase), "R2", "phase vs model", phase, refPhase);
      check(flush == refFlush, "R6", "flush vs model", flush, refFlush);
      check(pc[0] == 1'b0, "R9", "pc bit0", pc[0], 0);
    end
  end

  task automatic doInstr(input logic [15:0] w, input logic c);
    instrWord = w; carryIn = c;
    repeat (4) @(negedge clk);
  endtask

  // carry is the inverse of q3Level outside Q3 and equals q3Level in Q3
  task automatic doCarryQ3(input logic [15:0] w, input logic q3Level);
    instrWord = w; carryIn = !q3Level;
    repeat (2) @(negedge clk);
    carryIn = q3Level;
    @(negedge clk);
    carryIn = !q3Level;
    @(negedge clk);
  endtask

  task automatic expectPc(input string req, input logic [PC_W-1:0] e, input bit f);
    check(pc == e, req, "pc", pc, e);
    check(flush == f, req, "flush", flush, f);
  endtask

  task automatic finishRun;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 2000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(pc == 16'h0000, "R1", "reset pc", pc, 0);
    check(phase == 2'd0, "R1", "reset phase", phase, 0);
    check(flush == 1'b0, "R1", "reset flush", flush, 0);
    rstN = 1'b1;

    doInstr(16'h0000, 1'b1); expectPc("R5", 16'h0002, 1'b0);
    doInstr(16'hE205, 1'b0); expectPc("R10", 16'h0004, 1'b0);   // next exec at A+2
    doInstr(16'hE205, 1'b1); expectPc("R10", 16'h000E, 1'b1);   // A=2 -> A+12
    doInstr(16'hE280, 1'b1); expectPc("R7", 16'h0010, 1'b0);    // ignored in flush
    doInstr(16'hE280, 1'b1); expectPc("R8", 16'hFF10, 1'b1);    // n=-128 wraps down
    doInstr(16'h0000, 1'b0); expectPc("R6", 16'hFF12, 1'b0);
    doInstr(16'hE27F, 1'b1); expectPc("R8", 16'h0010, 1'b1);    // n=127 wraps up
    doInstr(16'h0000, 1'b0); expectPc("R6", 16'h0012, 1'b0);
    doInstr(16'hE37F, 1'b1); expectPc("R5", 16'h0014, 1'b0);    // other opcode
    doInstr(16'hE2FF, 1'b1); expectPc("R4", 16'h0012, 1'b1);    // n=-1
    doInstr(16'h0000, 1'b1); expectPc("R7", 16'h0014, 1'b0);
    doCarryQ3(16'hE202, 1'b1); expectPc("R4", 16'h0018, 1'b1);  // carry only in Q3
    doInstr(16'h0000, 1'b0); expectPc("R6", 16'h001A, 1'b0);
    doCarryQ3(16'hE202, 1'b0); expectPc("R4", 16'h001C, 1'b0);  // carry low only in Q3
    doInstr(16'h0000, 1'b0); expectPc("R5", 16'h001E, 1'b0);

    finishRun();
  end
endmodule